// File: doc/BRIEF.md
# Self-Timed Program and Erase Controller

This block sits behind the serial command front end of a small nonvolatile word store. The store holds 1024 words of 16 bits, and the same storage can be addressed as 2048 bytes. The front end shifts in an instruction and decodes it. It then presents the instruction to this block as a one-cycle strobe while chip select is high. The block keeps the erase/write enable latch and applies the program-enable pin. When chip select falls after an accepted program instruction, it runs a self-timed cycle that needs no serial clock.

During that cycle, `busy` stays high for a fixed number of system clocks, which stands in for the program pulse width. The array is updated within the same window. A single-word write clears and stores the word in one step, so a separate erase is never needed. Whole-array fill and clear walk every word, one word per clock.

In byte organisation, a single-location operation touches only one lane of a storage word. A registered word read port lets the front end read the array at any time.

Top module: `prog_ctrl_top`

## Requirements
- R1: After reset the enable latch is cleared. Enable (`cmdOp`=5) sets it and disable (`cmdOp`=6) clears it. While the latch is cleared, write (1), erase (2), clear-all (3) and fill-all (4) leave the array unchanged and never raise `busy`. Reset clears the latch but leaves the array contents intact.
- R2: A program operation runs only if `progEn` is 1 on the clock edge where chip select is first sampled low. Enable and disable take effect whatever the value of `progEn`.
- R3: A command is accepted when `cmdValid` is high with `cs` high. A program operation starts only at the first clock edge that samples `cs` low after it was high, following an accepted program command. `busy` is high in the cycle after that edge. A `cs` fall with no pending command starts nothing, and `cs` held high keeps the command pending.
- R4: Erase sets the addressed location to all ones. Clear-all sets every word to 16'hFFFF.
- R5: Write replaces the addressed word with `cmdData` without a prior erase.
- R6: Fill-all stores the data word into every word of the array.
- R7: `busy` stays high for exactly `PROG_CYCLES` consecutive clock cycles per operation.
- R8: `rdData` shows the word at `rdAddr` one clock after `rdAddr` is sampled, whatever the state of the latch.
- R9: Every command presented while `busy` is high is ignored: the running cycle keeps its length, and its result is not replaced.
- R10: With `byteMode`=1, `cmdAddr`[10:1] selects the word and `cmdAddr`[0] selects the upper (1) or lower (0) byte. Write and erase change only that byte and leave the other byte of the word unchanged. Fill-all copies `cmdData`[7:0] into both bytes of every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select level from the front end |
| cmdValid | input | 1 | One-cycle strobe for a decoded command |
| cmdOp | input | 3 | Command code: 0 none, 1 write, 2 erase, 3 clear-all, 4 fill-all, 5 enable, 6 disable |
| cmdAddr | input | 11 | Location address; bit 0 is the byte select in byte mode |
| cmdData | input | 16 | Write data (low byte used in byte mode) |
| byteMode | input | 1 | 1 selects byte organisation |
| progEn | input | 1 | Program-enable pin |
| rdAddr | input | 10 | Word read address |
| rdData | output | 16 | Registered read data |
| busy | output | 1 | High while a self-timed cycle runs |

## Verification
The bench checks that a blocked program command, blocked either by the latch or by `progEn`, never raises `busy`. A design that checked only one of the two gates would start a cycle and corrupt a word. It presents a second command in the middle of a running cycle; a design that re-arms would stretch `busy` or overwrite the first result. Byte writes and byte erases are checked against the neighbouring byte, which a whole-word store would wipe. A reset taken after enable must leave the latch off and the array unchanged.

// File: rtl/prog_ctrl_pkg.sv
package prog_ctrl_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_CLRALL = 3'd3,
    OP_FILLALL = 3'd4,
    OP_ENABLE = 3'd5,
    OP_DISABLE = 3'd6
  } progOpT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch command fields
    logic store;      // write one word this cycle
    logic sweep;      // word index comes from the step counter
    logic clearData;  // store ones instead of command data
  } progStrbT;
endpackage

// File: rtl/prog_ctrl_fsm.sv
module prog_ctrl_fsm
  import prog_ctrl_pkg::*;
#(
  parameter int WORD_ADDR_W = 10,
  parameter int PROG_CYCLES = 1100,
  localparam int DEPTH = 1 << WORD_ADDR_W,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cs,
  input  logic                   cmdValid,
  input  logic [2:0]             cmdOp,
  input  logic                   progEn,
  output logic                   busy,
  output progStrbT               strb,
  output logic [WORD_ADDR_W-1:0] stepIdx
);
  progOpT opIn, armedOp, runOp;
  logic csPrev, armed, wel, csFall, accept, isProg;
  logic [CNT_W-1:0] cnt;

  assign opIn   = progOpT'(cmdOp);
  assign isProg = (opIn == OP_WRITE) || (opIn == OP_ERASE) ||
                  (opIn == OP_CLRALL) || (opIn == OP_FILLALL);
  assign accept = cmdValid && cs && !busy;
  assign csFall = csPrev && !cs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b0;
      armed   <= 1'b0;
      armedOp <= OP_NONE;
      runOp   <= OP_NONE;
      wel     <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
    end else begin
      csPrev <= cs;
      if (accept) begin
        unique case (opIn)
          OP_ENABLE:  begin wel <= 1'b1; armed <= 1'b0; end
          OP_DISABLE: begin wel <= 1'b0; armed <= 1'b0; end
          default: begin
            armed   <= isProg;
            armedOp <= opIn;
          end
        endcase
      end
      if (csFall) begin
        armed <= 1'b0;
        if (armed && wel && progEn && !busy) begin
          busy  <= 1'b1;
          cnt   <= '0;
          runOp <= armedOp;
        end
      end
      if (busy) begin
        if (cnt == CNT_W'(PROG_CYCLES - 1)) busy <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end
  end

  logic sweepOp;
  assign sweepOp        = (runOp == OP_CLRALL) || (runOp == OP_FILLALL);
  assign strb.capture   = accept && isProg;
  assign strb.sweep     = sweepOp;
  assign strb.clearData = (runOp == OP_ERASE) || (runOp == OP_CLRALL);
  assign strb.store     = busy && (sweepOp ? (cnt < CNT_W'(DEPTH)) : (cnt == '0));
  assign stepIdx        = cnt[WORD_ADDR_W-1:0];
endmodule

// File: rtl/prog_ctrl_datapath.sv
module prog_ctrl_datapath
  import prog_ctrl_pkg::*;
#(
  parameter int WORD_ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << WORD_ADDR_W,
  localparam int LANE_W = DATA_W / 2,
  localparam int CMD_ADDR_W = WORD_ADDR_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  progStrbT               strb,
  input  logic [WORD_ADDR_W-1:0] stepIdx,
  input  logic [CMD_ADDR_W-1:0]  cmdAddr,
  input  logic [DATA_W-1:0]      cmdData,
  input  logic                   byteMode,
  input  logic [WORD_ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]      rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [CMD_ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic capByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
      capByte <= 1'b0;
    end else if (strb.capture) begin
      capAddr <= cmdAddr;
      capData <= cmdData;
      capByte <= byteMode;
    end
  end

  logic [WORD_ADDR_W-1:0] wordSel;
  logic [DATA_W-1:0] fillWord, oldWord, newWord;
  logic [1:0] laneEn;

  always_comb begin
    if (strb.sweep)   wordSel = stepIdx;
    else if (capByte) wordSel = capAddr[CMD_ADDR_W-1:1];
    else              wordSel = capAddr[WORD_ADDR_W-1:0];
    if (strb.clearData) fillWord = '1;
    else if (capByte)   fillWord = {2{capData[LANE_W-1:0]}};
    else                fillWord = capData;
    if (capByte && !strb.sweep) laneEn = capAddr[0] ? 2'b10 : 2'b01;
    else                        laneEn = 2'b11;
  end

  assign oldWord = mem[wordSel];

  // Per-lane merge keeps the unselected byte of a word intact
  for (genvar g = 0; g < 2; g++) begin : gLane
    assign newWord[g*LANE_W +: LANE_W] = laneEn[g] ? fillWord[g*LANE_W +: LANE_W]
                                                   : oldWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.store) mem[wordSel] <= newWord;
    rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/prog_ctrl_top.sv
module prog_ctrl_top
  import prog_ctrl_pkg::*;
#(
  parameter int WORD_ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int PROG_CYCLES = 1100,  // must be at least 2**WORD_ADDR_W
  localparam int CMD_ADDR_W = WORD_ADDR_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cs,
  input  logic                   cmdValid,
  input  logic [2:0]             cmdOp,
  input  logic [CMD_ADDR_W-1:0]  cmdAddr,
  input  logic [DATA_W-1:0]      cmdData,
  input  logic                   byteMode,
  input  logic                   progEn,
  input  logic [WORD_ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]      rdData,
  output logic                   busy
);
  progStrbT strb;
  logic [WORD_ADDR_W-1:0] stepIdx;

  prog_ctrl_fsm #(.WORD_ADDR_W(WORD_ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_fsm (
    .clk(clk), .rstN(rstN), .cs(cs), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .progEn(progEn), .busy(busy), .strb(strb), .stepIdx(stepIdx)
  );

  prog_ctrl_datapath #(.WORD_ADDR_W(WORD_ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stepIdx(stepIdx), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .byteMode(byteMode), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/prog_ctrl_checker.sv
module prog_ctrl_checker #(
  parameter int PROG_CYCLES = 1100,
  localparam int CNT_W = $clog2(PROG_CYCLES + 2)
) (
  input logic       clk,
  input logic       rstN,
  input logic       cs,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic       progEn,
  input logic       busy
);
  logic welSeen;
  logic [CNT_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welSeen <= 1'b0;
      busyRun <= '0;
    end else begin
      if (cmdValid && cs && !busy && cmdOp == 3'd5) welSeen <= 1'b1;
      if (cmdValid && cs && !busy && cmdOp == 3'd6) welSeen <= 1'b0;
      busyRun <= busy ? busyRun + 1'b1 : '0;
    end
  end

  AST_START_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(!cs) && $past(cs, 2)));  // R3
  AST_START_NEEDS_PE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(progEn));  // R2
  AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(welSeen));  // R1
  AST_BUSY_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < CNT_W'(PROG_CYCLES)));  // R7
  AST_BUSY_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == CNT_W'(PROG_CYCLES)));  // R7
endmodule

bind prog_ctrl_top prog_ctrl_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .progEn(progEn), .busy(busy)
);

// File: tb/prog_ctrl_top_bench.sv
module prog_ctrl_top_bench;
  localparam int P = 1100;
  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, cmdValid = 1'b0, byteMode = 1'b0, progEn = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [10:0] cmdAddr = '0;
  logic [15:0] cmdData = '0;
  logic [9:0] rdAddr = '0;
  logic [15:0] rdData;
  logic busy;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  prog_ctrl_top #(.PROG_CYCLES(P)) u_prog_ctrl_top (
    .clk(clk), .rstN(rstN), .cs(cs), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .byteMode(byteMode), .progEn(progEn),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

  typedef struct packed {
    logic [2:0] op; logic [10:0] addr; logic [15:0] data; logic x8; logic pe;
    logic expBusy; logic doRd; logic [9:0] rdA; logic [15:0] rdExp; logic [3:0] req;
  } vecT;

  localparam vecT VEC [16] = '{
    '{3'd1, 11'd5,  16'h1234, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0,   16'h0000, 4'd1},  // R1 latch off
    '{3'd5, 11'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,   16'h0000, 4'd2},  // R2 enable with PE low
    '{3'd3, 11'd0,  16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 10'd777, 16'hFFFF, 4'd4},  // R4 clear-all
    '{3'd1, 11'd5,  16'hA5C3, 1'b0, 1'b1, 1'b1, 1'b1, 10'd5,   16'hA5C3, 4'd5},  // R5
    '{3'd1, 11'd5,  16'h1234, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5,   16'hA5C3, 4'd2},  // R2 PE low
    '{3'd1, 11'd5,  16'h0F0F, 1'b0, 1'b1, 1'b1, 1'b1, 10'd5,   16'h0F0F, 4'd5},  // R5 overwrite
    '{3'd2, 11'd5,  16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 10'd5,   16'hFFFF, 4'd4},  // R4 erase
    '{3'd4, 11'd0,  16'h3C96, 1'b0, 1'b1, 1'b1, 1'b1, 10'd1023,16'h3C96, 4'd6},  // R6 fill-all
    '{3'd1, 11'd21, 16'h00AB, 1'b1, 1'b1, 1'b1, 1'b1, 10'd10,  16'hAB96, 4'd10}, // R10 upper
    '{3'd1, 11'd20, 16'h0011, 1'b1, 1'b1, 1'b1, 1'b1, 10'd10,  16'hAB11, 4'd10}, // R10 lower
    '{3'd2, 11'd21, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 10'd10,  16'hFF11, 4'd10}, // R10 byte erase
    '{3'd4, 11'd0,  16'h0042, 1'b1, 1'b1, 1'b1, 1'b1, 10'd700, 16'h4242, 4'd10}, // R10 byte fill
    '{3'd6, 11'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0,   16'h0000, 4'd1},  // R1 disable
    '{3'd3, 11'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 10'd700, 16'h4242, 4'd8},  // R8 read, R1 blocked
    '{3'd5, 11'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0,   16'h0000, 4'd1},  // R1 re-enable
    '{3'd1, 11'd3,  16'h7777, 1'b0, 1'b1, 1'b1, 1'b1, 10'd3,   16'h7777, 4'd1}   // R1
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Presents a command with cs high, then drops cs; returns at the negedge after the start edge
  task automatic sendCmd(input logic [2:0] op, input logic [10:0] a, input logic [15:0] d,
                         input logic x8, input logic pe);
    @(negedge clk) cs = 1'b1;
    @(negedge clk) begin cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d; byteMode = x8; progEn = pe; end
    @(negedge clk) begin cmdValid = 1'b0; cmdOp = 3'd0; end
    @(negedge clk) cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic readWord(input logic [9:0] a, input logic [15:0] exp, input string req);
    @(negedge clk) rdAddr = a;
    @(negedge clk) check(rdData === exp, req, 32'(rdData), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R7 watchdog expired actual=busy%0b expected=done", busy);
    $display("%0d/%0d checks passed", nChk + 1 - nFail, nChk + 1);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk) check(busy === 1'b0, "R1 reset busy", 32'(busy), 0);

    foreach (VEC[i]) begin
      sendCmd(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].x8, VEC[i].pe);
      check(busy === VEC[i].expBusy, $sformatf("R%0d busy vec%0d", VEC[i].req, i),
            32'(busy), 32'(VEC[i].expBusy));
      waitIdle(n);
      if (VEC[i].expBusy) check(n == P, $sformatf("R7 length vec%0d", i), 32'(n), 32'(P));
      if (VEC[i].doRd) readWord(VEC[i].rdA, VEC[i].rdExp, $sformatf("R%0d data vec%0d", VEC[i].req, i));
    end

    // R9: a second command during a running cycle is ignored
    sendCmd(3'd1, 11'd9, 16'h1111, 1'b0, 1'b1);
    n = busy ? 1 : 0;
    @(negedge clk) begin cs = 1'b1; if (busy) n++; end
    @(negedge clk) begin cmdValid = 1'b1; cmdOp = 3'd1; cmdData = 16'h2222; if (busy) n++; end
    @(negedge clk) begin cmdValid = 1'b0; cmdOp = 3'd0; if (busy) n++; end
    @(negedge clk) begin cs = 1'b0; if (busy) n++; end
    while (busy) begin @(negedge clk); if (busy) n++; end
    check(n == P, "R9 length unchanged", 32'(n), 32'(P));
    repeat (5) @(negedge clk);
    check(busy === 1'b0, "R9 no restart", 32'(busy), 0);
    readWord(10'd9, 16'h1111, "R9 first result kept");

    // R3: cs held high keeps the command pending
    @(negedge clk) cs = 1'b1;
    @(negedge clk) begin cmdValid = 1'b1; cmdOp = 3'd1; cmdAddr = 11'd4; cmdData = 16'h4444; end
    @(negedge clk) begin cmdValid = 1'b0; cmdOp = 3'd0; end
    repeat (10) @(negedge clk);
    check(busy === 1'b0, "R3 no start while cs high", 32'(busy), 0);
    cs = 1'b0;
    @(negedge clk) check(busy === 1'b1, "R3 start on cs fall", 32'(busy), 1);
    waitIdle(n);
    readWord(10'd4, 16'h4444, "R3 pending write done");

    // R3: cs fall with nothing pending
    @(negedge clk) cs = 1'b1;
    @(negedge clk) cs = 1'b0;
    @(negedge clk) check(busy === 1'b0, "R3 empty cs fall", 32'(busy), 0);

    // R1: reset clears the latch, array retained
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk) check(busy === 1'b0, "R1 busy after reset", 32'(busy), 0);
    sendCmd(3'd1, 11'd4, 16'h0000, 1'b0, 1'b1);
    check(busy === 1'b0, "R1 latch cleared by reset", 32'(busy), 0);
    readWord(10'd4, 16'h4444, "R1 array kept over reset");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule